// File: doc/BRIEF.md
# OTP Trim Interface Host Sequencer

This block is the master side of a three-wire serial link to a one-time-programmable trim register. The wires are chip select, clock and a bidirectional data pin. A command names one of four operations: reload the register from the fuses, read the register back, write the register, or burn the register into the fuses. The command also gives a bit count of at most 54 and a parallel write word. The sequencer then plays out the pin choreography on its own. That choreography is an entry pattern that takes the pins away from their normal serial use, a preamble that selects the operation, the data clocking and an exit pattern.

Each pin change is one step. A step holds the pins for a configured number of system-clock cycles. During a burn, the clock-high and clock-low steps take their own counts instead, so pulses of tens of microseconds come from the same engine. Read data is assembled into a parallel word. A separate output enable lets the data pin be released while the trim register drives it.

The command side is a valid/ready handshake with no back-pressure beyond `cmd_ready`. A command is taken on a cycle where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` stays low from the cycle after acceptance until the transaction ends, and `cmd_valid` raised in that window is dropped. `done` marks the end for one cycle. From then on, `rd_data` holds its value until the next acceptance.

Top module: `otp_host_seq`

## Requirements
- R1: Out of reset and whenever no command runs, the pins rest at chip select 1, clock 1, data 0, data enable 1, with `busy` 0, `done` 0 and `cmd_ready` 1.
- R2: A command is accepted on a clock where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 and `busy` is 1 until the transaction ends. A `cmd_valid` seen while busy changes neither the running pin sequence nor the next operation.
- R3: The first step is applied in the cycle after acceptance. Each step changes at most one pin and holds it for `cfg_step_cycles` cycles, with 0 counting as 1; burn steps are the exception (R8).
- R4: The entry pattern, in order, is: chip select 0, clock 0, data 1, chip select 1, chip select 0, clock 1, clock 0.
- R5: Reload (`cmd_op`=0) sends data 0, then chip select 1, then 4 clock pulses, then one clock pulse per bit. A pulse is clock 1 followed by clock 0.
- R6: Write (`cmd_op`=2) sends chip select 1 and 3 pulses. Each bit, from index n-1 down to 0 of `cmd_wdata`, is then put on data one step before its pulse. A latch tail follows: data 1, then one pulse.
- R7: Read (`cmd_op`=1) sends data 0, clock 1, chip select 1, clock 0, one pulse, data enable 0, one pulse. The first bit is sampled one step later. Each further bit is sampled at the end of a clock-high step. Bit n-1 is taken first and lands in `rd_data[n-1]`; bits n and up are 0.
- R8: Burn (`cmd_op`=3) sends clock 1, chip select 1, clock 0 and 4 pulses. It then gives one pulse per bit, whose high step lasts `cfg_burn_cycles` and whose low step lasts `cfg_recharge_cycles` (0 counts as 1).
- R9: The exit pattern is: data enable 1, chip select 0, clock 1, clock 0, clock 1, chip select 1, data 0. `done` is 1 for exactly one cycle, right after the last exit step's hold.
- R10: A bit count above 54 is treated as 54. A count of 0 gives no data pulses, but every other part of the sequence is kept.
- R11: `rd_data` is cleared on acceptance. It stays 0 for every operation except read, and it holds its value after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High when a command can be taken |
| cmd_op | input | 2 | 0 reload, 1 read, 2 write, 3 burn |
| cmd_nbits | input | 6 | Number of trim bits |
| cmd_wdata | input | 54 | Write word, bit n-1 sent first |
| cfg_step_cycles | input | 16 | Hold of each ordinary step |
| cfg_burn_cycles | input | 16 | Clock-high hold during a burn |
| cfg_recharge_cycles | input | 16 | Clock-low hold during a burn |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end marker |
| rd_data | output | 54 | Assembled read word |
| otp_csn | output | 1 | Chip select pin |
| otp_clk | output | 1 | Serial clock pin |
| otp_dout | output | 1 | Value driven on the data pin |
| otp_doe | output | 1 | Data pin drive enable, 0 = released |
| otp_din | input | 1 | Value seen on the data pin |

## Verification
The first step of a command shows up one cycle after the accepting edge. From there, every step lasts exactly its configured count, 0 counting as 1. `done` follows one cycle after the last exit step's hold, and `rd_data` is final in that same cycle. The bench turns the requirements into an expected per-cycle pin queue and compares every negative edge against the next entry. At the cycle the queue runs dry, it checks `done` and `rd_data`, and one cycle later it checks that `done` has dropped. A behavioural trim-register model presents read bits that advance on rising serial clocks, so a sampling point moved by even one step shows up as a wrong bit.

// File: rtl/otp_host_pkg.sv
package otp_host_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_PROG  = 2'd3
  } otp_op_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ENTRY = 3'd1,
    PH_PRE   = 3'd2,
    PH_DATA  = 3'd3,
    PH_TAIL  = 3'd4,
    PH_EXIT  = 3'd5
  } otp_phase_e;

  typedef enum logic [1:0] {
    PIN_CSN  = 2'd0,
    PIN_CLK  = 2'd1,
    PIN_DOUT = 2'd2,
    PIN_DOE  = 2'd3
  } otp_pin_e;

  typedef enum logic [1:0] {
    DLY_STEP  = 2'd0,
    DLY_BURN  = 2'd1,
    DLY_RECHG = 2'd2
  } otp_dly_e;

  typedef struct packed {
    otp_pin_e pin;
    logic     val;
  } otp_evt_t;

  localparam int EVT_IDX_W = 4;

  function automatic otp_evt_t mk_evt(otp_pin_e p, logic v);
    otp_evt_t e;
    e.pin = p;
    e.val = v;
    return e;
  endfunction

  // index of the final step inside a phase
  function automatic logic [EVT_IDX_W-1:0] phase_last(otp_op_e op, otp_phase_e ph);
    logic [EVT_IDX_W-1:0] r;
    case (ph)
      PH_ENTRY: r = 4'd6;
      PH_PRE: begin
        case (op)
          OP_LOAD:  r = 4'd9;
          OP_WRITE: r = 4'd6;
          OP_READ:  r = 4'd8;
          default:  r = 4'd10;
        endcase
      end
      PH_DATA: r = (op == OP_WRITE) ? 4'd2 : 4'd1;
      PH_TAIL: r = 4'd2;
      PH_EXIT: r = 4'd6;
      default: r = 4'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/otp_step_timer.sv
module otp_step_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expire
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= (len == '0) ? '0 : len - 1'b1;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == '0);

  // a step longer than one cycle must not end in the cycle after it starts
  p_step_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && len > 1) |=> !expire);
endmodule

// File: rtl/otp_bit_shift.sv
module otp_bit_shift #(
  parameter int MAXB = 54,
  parameter int NB_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NB_W-1:0] nbits,
  input  logic [MAXB-1:0] wdata,
  input  logic            wr_shift,
  input  logic            rd_capture,
  input  logic            din,
  output logic            wr_bit,
  output logic [MAXB-1:0] rd_word
);
  logic [MAXB-1:0] wsh;
  logic [MAXB-1:0] rsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsh <= '0;
      rsh <= '0;
    end else begin
      if (start)         wsh <= wdata << (NB_W'(MAXB) - nbits);
      else if (wr_shift) wsh <= {wsh[MAXB-2:0], 1'b0};
      if (start)           rsh <= '0;
      else if (rd_capture) rsh <= {rsh[MAXB-2:0], din};
    end
  end

  assign wr_bit  = wsh[MAXB-1];
  assign rd_word = rsh;

  p_rd_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (rd_word == '0));
endmodule

// File: rtl/otp_evt_decode.sv
module otp_evt_decode
  import otp_host_pkg::*;
(
  input  otp_op_e              op,
  input  otp_phase_e           phase,
  input  logic [EVT_IDX_W-1:0] idx,
  input  logic                 wr_bit,
  input  logic                 first_bit,
  output otp_evt_t             evt,
  output otp_dly_e             dly
);
  always_comb begin
    evt = mk_evt(PIN_CLK, 1'b0);
    dly = DLY_STEP;
    case (phase)
      PH_ENTRY: begin
        case (idx)
          4'd0:    evt = mk_evt(PIN_CSN, 1'b0);
          4'd1:    evt = mk_evt(PIN_CLK, 1'b0);
          4'd2:    evt = mk_evt(PIN_DOUT, 1'b1);
          4'd3:    evt = mk_evt(PIN_CSN, 1'b1);
          4'd4:    evt = mk_evt(PIN_CSN, 1'b0);
          4'd5:    evt = mk_evt(PIN_CLK, 1'b1);
          default: evt = mk_evt(PIN_CLK, 1'b0);
        endcase
      end
      PH_PRE: begin
        case (op)
          OP_LOAD: begin
            if (idx == 4'd0)      evt = mk_evt(PIN_DOUT, 1'b0);
            else if (idx == 4'd1) evt = mk_evt(PIN_CSN, 1'b1);
            else                  evt = mk_evt(PIN_CLK, ~idx[0]);
          end
          OP_WRITE: begin
            if (idx == 4'd0) evt = mk_evt(PIN_CSN, 1'b1);
            else             evt = mk_evt(PIN_CLK, idx[0]);
          end
          OP_READ: begin
            case (idx)
              4'd0:    evt = mk_evt(PIN_DOUT, 1'b0);
              4'd1:    evt = mk_evt(PIN_CLK, 1'b1);
              4'd2:    evt = mk_evt(PIN_CSN, 1'b1);
              4'd3:    evt = mk_evt(PIN_CLK, 1'b0);
              4'd4:    evt = mk_evt(PIN_CLK, 1'b1);
              4'd5:    evt = mk_evt(PIN_CLK, 1'b0);
              4'd6:    evt = mk_evt(PIN_DOE, 1'b0);
              4'd7:    evt = mk_evt(PIN_CLK, 1'b1);
              default: evt = mk_evt(PIN_CLK, 1'b0);
            endcase
          end
          default: begin
            if (idx == 4'd0)      evt = mk_evt(PIN_CLK, 1'b1);
            else if (idx == 4'd1) evt = mk_evt(PIN_CSN, 1'b1);
            else if (idx == 4'd2) evt = mk_evt(PIN_CLK, 1'b0);
            else                  evt = mk_evt(PIN_CLK, idx[0]);
          end
        endcase
      end
      PH_DATA: begin
        case (op)
          OP_WRITE: begin
            if (idx == 4'd0)      evt = mk_evt(PIN_DOUT, wr_bit);
            else if (idx == 4'd1) evt = mk_evt(PIN_CLK, 1'b1);
            else                  evt = mk_evt(PIN_CLK, 1'b0);
          end
          OP_READ: begin
            if (idx == 4'd0) evt = mk_evt(PIN_CLK, ~first_bit);
            else             evt = mk_evt(PIN_CLK, 1'b0);
          end
          OP_PROG: begin
            if (idx == 4'd0) begin
              evt = mk_evt(PIN_CLK, 1'b1);
              dly = DLY_BURN;
            end else begin
              evt = mk_evt(PIN_CLK, 1'b0);
              dly = DLY_RECHG;
            end
          end
          default: evt = mk_evt(PIN_CLK, (idx == 4'd0));
        endcase
      end
      PH_TAIL: begin
        if (idx == 4'd0)      evt = mk_evt(PIN_DOUT, 1'b1);
        else if (idx == 4'd1) evt = mk_evt(PIN_CLK, 1'b1);
        else                  evt = mk_evt(PIN_CLK, 1'b0);
      end
      PH_EXIT: begin
        case (idx)
          4'd0:    evt = mk_evt(PIN_DOE, 1'b1);
          4'd1:    evt = mk_evt(PIN_CSN, 1'b0);
          4'd2:    evt = mk_evt(PIN_CLK, 1'b1);
          4'd3:    evt = mk_evt(PIN_CLK, 1'b0);
          4'd4:    evt = mk_evt(PIN_CLK, 1'b1);
          4'd5:    evt = mk_evt(PIN_CSN, 1'b1);
          default: evt = mk_evt(PIN_DOUT, 1'b0);
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/otp_host_seq.sv
module otp_host_seq
  import otp_host_pkg::*;
#(
  parameter int MAX_BITS = 54,
  parameter int DLY_W    = 16,
  localparam int NB_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [1:0]          cmd_op,
  input  logic [NB_W-1:0]     cmd_nbits,
  input  logic [MAX_BITS-1:0] cmd_wdata,
  input  logic [DLY_W-1:0]    cfg_step_cycles,
  input  logic [DLY_W-1:0]    cfg_burn_cycles,
  input  logic [DLY_W-1:0]    cfg_recharge_cycles,
  output logic                busy,
  output logic                done,
  output logic [MAX_BITS-1:0] rd_data,
  output logic                otp_csn,
  output logic                otp_clk,
  output logic                otp_dout,
  output logic                otp_doe,
  input  logic                otp_din
);
  otp_phase_e           phase_q, tgt_phase;
  otp_op_e              op_q;
  logic [EVT_IDX_W-1:0] idx_q, tgt_idx, cur_last;
  logic [NB_W-1:0]      bits_left_q, n_clamp;
  logic                 first_q, tgt_first, done_q;
  logic [DLY_W-1:0]     step_q, burn_q, rch_q, tgt_len;
  logic                 csn_q, clk_q, dout_q, doe_q;
  logic                 idle, accept, go, expire, wr_bit;
  otp_evt_t             tgt_evt;
  otp_dly_e             tgt_dly;
  otp_phase_e           after_data;
  logic                 bit_done;

  assign idle      = (phase_q == PH_IDLE);
  assign accept    = cmd_valid && idle;
  assign go        = accept || (!idle && expire);
  assign n_clamp   = (cmd_nbits > NB_W'(MAX_BITS)) ? NB_W'(MAX_BITS) : cmd_nbits;
  assign cur_last  = phase_last(op_q, phase_q);
  assign after_data = (op_q == OP_WRITE) ? PH_TAIL : PH_EXIT;
  assign bit_done  = (phase_q == PH_DATA) && (idx_q == cur_last);
  assign tgt_first = first_q && !bit_done;

  // choose the step that follows the current one
  always_comb begin
    tgt_phase = phase_q;
    tgt_idx   = idx_q + 1'b1;
    if (idle) begin
      tgt_phase = PH_ENTRY;
      tgt_idx   = '0;
    end else if (idx_q == cur_last) begin
      tgt_idx = '0;
      case (phase_q)
        PH_ENTRY: tgt_phase = PH_PRE;
        PH_PRE:   tgt_phase = (bits_left_q != '0) ? PH_DATA : after_data;
        PH_DATA:  tgt_phase = (bits_left_q > 1) ? PH_DATA : after_data;
        PH_TAIL:  tgt_phase = PH_EXIT;
        default:  tgt_phase = PH_IDLE;
      endcase
    end
  end

  otp_evt_decode u_dec (
    .op        (op_q),
    .phase     (tgt_phase),
    .idx       (tgt_idx),
    .wr_bit    (wr_bit),
    .first_bit (tgt_first),
    .evt       (tgt_evt),
    .dly       (tgt_dly)
  );

  always_comb begin
    case (tgt_dly)
      DLY_BURN:  tgt_len = burn_q;
      DLY_RECHG: tgt_len = rch_q;
      default:   tgt_len = idle ? cfg_step_cycles : step_q;
    endcase
  end

  otp_step_timer #(.W(DLY_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (go && (tgt_phase != PH_IDLE)),
    .len    (tgt_len),
    .expire (expire)
  );

  otp_bit_shift #(.MAXB(MAX_BITS), .NB_W(NB_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .nbits      (n_clamp),
    .wdata      (cmd_wdata),
    .wr_shift   (go && tgt_phase == PH_DATA && tgt_idx == '0 && op_q == OP_WRITE),
    .rd_capture (go && phase_q == PH_DATA && idx_q == '0 && op_q == OP_READ),
    .din        (otp_din),
    .wr_bit     (wr_bit),
    .rd_word    (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      idx_q       <= '0;
      op_q        <= OP_LOAD;
      bits_left_q <= '0;
      first_q     <= 1'b0;
      done_q      <= 1'b0;
      step_q      <= '0;
      burn_q      <= '0;
      rch_q       <= '0;
      csn_q       <= 1'b1;
      clk_q       <= 1'b1;
      dout_q      <= 1'b0;
      doe_q       <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        op_q        <= otp_op_e'(cmd_op);
        bits_left_q <= n_clamp;
        first_q     <= 1'b1;
        step_q      <= cfg_step_cycles;
        burn_q      <= cfg_burn_cycles;
        rch_q       <= cfg_recharge_cycles;
      end
      if (go) begin
        phase_q <= tgt_phase;
        idx_q   <= tgt_idx;
        if (tgt_phase == PH_IDLE) begin
          done_q <= 1'b1;
        end else begin
          case (tgt_evt.pin)
            PIN_CSN:  csn_q  <= tgt_evt.val;
            PIN_CLK:  clk_q  <= tgt_evt.val;
            PIN_DOUT: dout_q <= tgt_evt.val;
            default:  doe_q  <= tgt_evt.val;
          endcase
        end
        if (bit_done) begin
          bits_left_q <= bits_left_q - 1'b1;
          first_q     <= 1'b0;
        end
      end
    end
  end

  assign cmd_ready = idle;
  assign busy      = !idle;
  assign done      = done_q;
  assign otp_csn   = csn_q;
  assign otp_clk   = clk_q;
  assign otp_dout  = dout_q;
  assign otp_doe   = doe_q;

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (otp_csn && otp_clk && !otp_dout && otp_doe));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!otp_csn && busy));

  p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> $stable(op_q));

  p_one_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({otp_csn, otp_clk, otp_dout, otp_doe} ^
               $past({otp_csn, otp_clk, otp_dout, otp_doe})) <= 1);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !expire) |=> $stable({otp_csn, otp_clk, otp_dout, otp_doe}));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !otp_doe |-> (op_q == OP_READ));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/otp_host_seq_test.sv
module otp_host_seq_test;
  localparam int MAXB = 54;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic [5:0]  cmd_nbits = 6'd0;
  logic [MAXB-1:0] cmd_wdata = '0;
  logic [15:0] cfg_step = 16'd1, cfg_burn = 16'd1, cfg_rch = 16'd1;
  logic        busy, done;
  logic [MAXB-1:0] rd_data;
  logic        otp_csn, otp_clk, otp_dout, otp_doe, otp_din;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  otp_host_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_nbits(cmd_nbits), .cmd_wdata(cmd_wdata),
    .cfg_step_cycles(cfg_step), .cfg_burn_cycles(cfg_burn),
    .cfg_recharge_cycles(cfg_rch), .busy(busy), .done(done), .rd_data(rd_data),
    .otp_csn(otp_csn), .otp_clk(otp_clk), .otp_dout(otp_dout),
    .otp_doe(otp_doe), .otp_din(otp_din)
  );

  // behavioural trim register: shifts out bit n-1 first, one bit per rising clock
  int dev_k = 0;
  int dev_n = 0;
  logic [MAXB-1:0] dev_pat = '0;
  always @(negedge otp_doe) dev_k = 0;
  always @(posedge otp_clk) if (!otp_doe) dev_k = dev_k + 1;
  assign otp_din = (!otp_doe && dev_k >= 1 && dev_k <= dev_n) ? dev_pat[dev_n - dev_k] : 1'b0;

  // expected pin stream, one entry per clock cycle
  logic [3:0] exp_q[$];
  string      tag_q[$];
  bit m_csn, m_clk, m_dout, m_doe;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic ev(input int pin, input bit v, input int d, input string tag);
    case (pin)
      0: m_csn = v;
      1: m_clk = v;
      2: m_dout = v;
      default: m_doe = v;
    endcase
    for (int k = 0; k < ((d == 0) ? 1 : d); k++) begin
      exp_q.push_back({m_csn, m_clk, m_dout, m_doe});
      tag_q.push_back(tag);
    end
  endtask

  task automatic pulses(input int cnt, input int d, input string tag);
    for (int k = 0; k < cnt; k++) begin
      ev(1, 1'b1, d, tag);
      ev(1, 1'b0, d, tag);
    end
  endtask

  task automatic build(input int op, input int n, input logic [MAXB-1:0] wd,
                       input int st, input int bu, input int rc);
    m_csn = 1; m_clk = 1; m_dout = 0; m_doe = 1;
    // R4 entry
    ev(0, 0, st, "R4"); ev(1, 0, st, "R4"); ev(2, 1, st, "R4");
    ev(0, 1, st, "R4"); ev(0, 0, st, "R4"); ev(1, 1, st, "R4"); ev(1, 0, st, "R4");
    case (op)
      0: begin // R5 reload
        ev(2, 0, st, "R5"); ev(0, 1, st, "R5"); pulses(4, st, "R5");
        pulses(n, st, "R5");
      end
      2: begin // R6 write
        ev(0, 1, st, "R6"); pulses(3, st, "R6");
        for (int i = n - 1; i >= 0; i--) begin
          ev(2, wd[i], st, "R6"); ev(1, 1, st, "R6"); ev(1, 0, st, "R6");
        end
        ev(2, 1, st, "R6"); ev(1, 1, st, "R6"); ev(1, 0, st, "R6");
      end
      1: begin // R7 read
        ev(2, 0, st, "R7"); ev(1, 1, st, "R7"); ev(0, 1, st, "R7"); ev(1, 0, st, "R7");
        pulses(1, st, "R7"); ev(3, 0, st, "R7"); pulses(1, st, "R7");
        for (int i = 0; i < n; i++) begin
          ev(1, (i != 0), st, "R7"); ev(1, 0, st, "R7");
        end
      end
      default: begin // R8 burn
        ev(1, 1, st, "R8"); ev(0, 1, st, "R8"); ev(1, 0, st, "R8"); pulses(4, st, "R8");
        for (int i = 0; i < n; i++) begin
          ev(1, 1, bu, "R8"); ev(1, 0, rc, "R8");
        end
      end
    endcase
    // R9 exit
    ev(3, 1, st, "R9"); ev(0, 0, st, "R9"); ev(1, 1, st, "R9"); ev(1, 0, st, "R9");
    ev(1, 1, st, "R9"); ev(0, 1, st, "R9"); ev(2, 0, st, "R9");
  endtask

  task automatic run(input int op, input int nreq, input logic [MAXB-1:0] wd,
                     input int st, input int bu, input int rc,
                     input logic [MAXB-1:0] pat, input int poke_at);
    int n;
    int cyc;
    logic [3:0] e;
    string t;
    logic [MAXB-1:0] mask, exp_rd;
    n = (nreq > MAXB) ? MAXB : nreq;   // R10 clamp
    exp_q.delete(); tag_q.delete();
    build(op, n, wd, st, bu, rc);
    mask = (n == 0) ? '0 : ({MAXB{1'b1}} >> (MAXB - n));
    exp_rd = (op == 1) ? (pat & mask) : '0;
    dev_n = n; dev_pat = pat;
    @(negedge clk);
    cmd_op = op[1:0]; cmd_nbits = nreq[5:0]; cmd_wdata = wd;
    cfg_step = st[15:0]; cfg_burn = bu[15:0]; cfg_rch = rc[15:0];
    cmd_valid = 1'b1;
    chk(cmd_ready == 1'b1, "R2", "ready before accept", {63'd0, cmd_ready}, 64'd1);
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({otp_csn, otp_clk, otp_dout, otp_doe} == e, t, "pins csn/clk/dout/doe",
          {60'd0, otp_csn, otp_clk, otp_dout, otp_doe}, {60'd0, e});
      chk(busy && !cmd_ready && !done, "R2", "busy while running",
          {61'd0, busy, cmd_ready, done}, 64'd4);
      if (cyc == poke_at) begin
        cmd_valid = 1'b1;            // R2 request while busy must be dropped
        cmd_op = ~op[1:0];
      end else begin
        cmd_valid = 1'b0;
        cmd_op = op[1:0];
      end
      cyc++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R9", "done after exit hold",
        {62'd0, done, busy}, 64'd2);
    chk(rd_data == exp_rd, (op == 1) ? "R7" : "R11", "read word",
        {10'd0, rd_data}, {10'd0, exp_rd});
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one cycle", {63'd0, done}, 64'd0);
    chk({otp_csn, otp_clk, otp_dout, otp_doe} == 4'b1101 && cmd_ready, "R1", "idle pins",
        {59'd0, cmd_ready, otp_csn, otp_clk, otp_dout, otp_doe}, 64'h1d);
    chk(rd_data == exp_rd, "R11", "read word held", {10'd0, rd_data}, {10'd0, exp_rd});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({otp_csn, otp_clk, otp_dout, otp_doe} == 4'b1101, "R1", "reset pins",
        {60'd0, otp_csn, otp_clk, otp_dout, otp_doe}, 64'hd);
    chk(!busy && !done && cmd_ready, "R1", "reset status",
        {61'd0, busy, done, cmd_ready}, 64'd1);
    chk(rd_data == '0, "R11", "reset read word", {10'd0, rd_data}, 64'd0);

    run(2, 8,  54'h0000000000a5, 2, 1, 1, '0, 30);                  // R6 write, poke R2
    run(1, 54, 54'h0, 1, 1, 1, 54'h2b3c_4d5e_6f70_81, -1);           // R7 full read
    run(0, 5,  54'h0, 3, 1, 1, '0, -1);                              // R5 reload
    run(3, 3,  54'h0, 2, 12, 9, '0, 40);                             // R8 burn, poke R2
    run(2, 54, {27{2'b10}}, 1, 1, 1, '0, -1);                        // R6 checkerboard
    run(1, 1,  54'h0, 0, 1, 1, 54'h1, -1);                           // R3 zero step, R7 one bit
    run(2, 0,  54'h3ff, 1, 1, 1, '0, -1);                            // R10 no bits
    run(2, 60, {27{2'b01}}, 1, 1, 1, '0, -1);                        // R10 clamp
    run(1, 7,  54'h0, 2, 1, 1, 54'h3ffff_ffff_ff5a, 12);             // R7 upper bits zero
    run(3, 2,  54'h0, 1, 1000, 600, '0, -1);                         // R8 long pulses
    run(0, 0,  54'h0, 1, 1, 1, '0, -1);                              // R10 reload, no bits

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog R2 actual=busy expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule